// File: doc/BRIEF.md
# Command-Sequenced Bus Master

This block drives a 32-bit memory-mapped bus from a small stored program. After a start pulse it reads 64 command words, one after another, from an external command memory. Each 21-bit word selects one of four operations: do nothing, a burst of reads, a burst of writes, or a pause of a given number of cycles. Write data comes from an external 128-word data memory. A pointer into that memory starts at a value given in the command and advances by one on every write beat.

The program runs open-loop. The master takes no decision from what the slave returns. It stalls only while the slave holds waitrequest high. It issues pipelined reads back to back without waiting for their data. Every word the slave returns with readdatavalid high is passed, in order, to a result-FIFO push port. After the 64th command the master stays in a done state, and only reset leaves it. It is meant for driving a slave under test from a canned sequence of accesses.

Both memories are synchronous. Each returns data one cycle after its read strobe, and the sequencer spends that cycle explicitly.

Top module: `cmdseq_master`

## Requirements
- R1: While reset is active, bus_read, bus_write, res_push, cmd_rd and done are all low.
- R2: Before a start pulse the master issues no bus request. A start pulse taken in the idle state runs commands 0 to 63 in address order. A start pulse during a run or after completion has no effect.
- R3: A command word holds the opcode in bits [20:19], the bus address in [18:16], the count in [15:7] and the data pointer in [6:0]. The opcode values are 00 (no operation), 01 (read), 10 (write) and 11 (wait).
- R4: A read command with count c issues c reads to its address. Each read is accepted in a cycle where waitrequest is low. The next read follows at once, without waiting for readdatavalid.
- R5: A write command with count c issues c writes to its address. Beat k carries the data memory word at address (pointer + k) modulo 128.
- R6: A wait command with count c adds exactly c idle cycles and no bus request.
- R7: A read, write or wait command whose count is zero makes no bus request and takes the same time as a no-operation command.
- R8: While waitrequest is high, an outstanding request is held with its address and write data unchanged.
- R9: Each word returned with readdatavalid high is presented on res_data with res_push high one cycle later, in the order the words arrived.
- R10: After the 64th command, done goes high and stays high until reset. While done is high, no bus request and no memory strobe is made.
- R11: With no stalls, a command takes 3 cycles plus its body: c cycles for a read or a wait, 3c cycles for a write. Every cycle with waitrequest high during a request adds one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Start pulse, taken only in the idle state |
| cmd_addr | output | 6 | Command memory address |
| cmd_rd | output | 1 | Command memory read strobe |
| cmd_data | input | 21 | Command word, valid one cycle after cmd_rd |
| dat_addr | output | 7 | Data memory address |
| dat_rd | output | 1 | Data memory read strobe |
| dat_data | input | 32 | Data word, valid one cycle after dat_rd |
| bus_address | output | 3 | Bus address |
| bus_read | output | 1 | Bus read request |
| bus_write | output | 1 | Bus write request |
| bus_writedata | output | 32 | Bus write data |
| bus_waitrequest | input | 1 | Slave stall |
| bus_readdata | input | 32 | Returned read data |
| bus_readdatavalid | input | 1 | Returned read data is valid |
| res_push | output | 1 | Result FIFO push |
| res_data | output | 32 | Result FIFO data |
| done | output | 1 | Program complete |

## Verification
The bench samples all outputs 1 ns before each rising edge and drives slave inputs on the falling edge. A request counts as accepted only in a cycle where waitrequest was low at that sample point. A returned word is expected on the result port exactly one cycle after readdatavalid. The run length is checked against 3 cycles per command plus c for a read or a wait and 3c for a write, plus one cycle for each stalled request cycle the bench observed. Four runs use different generated programs and stall densities, which moves every accepted beat, so each write's data and each read's address are compared by order, not by cycle.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

  typedef enum logic [1:0] {
    OP_NOP   = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10,
    OP_DELAY = 2'b11
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_FETCH,
    S_DECODE,
    S_DLOAD,
    S_DCAP,
    S_WRITE,
    S_READ,
    S_DELAY,
    S_NEXT,
    S_DONE
  } st_e;

endpackage

// File: rtl/cmdseq_rst_sync.sv
module cmdseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/cmdseq_beat.sv
module cmdseq_beat #(
  parameter int BUS_AW = 3,
  parameter int CNT_W  = 9,
  parameter int DAT_AW = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BUS_AW-1:0] addr_in,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic [DAT_AW-1:0] ptr_in,
  input  logic              step,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] dat_in,
  output logic [BUS_AW-1:0] addr_q,
  output logic [DAT_AW-1:0] ptr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              last_beat
);

  localparam logic [CNT_W-1:0]  CNT_ONE = CNT_W'(1);
  localparam logic [DAT_AW-1:0] PTR_ONE = DAT_AW'(1);

  logic [CNT_W-1:0]  remain_q, remain_d;
  logic [DAT_AW-1:0] ptr_d;

  always_comb begin
    remain_d = remain_q;
    ptr_d    = ptr_q;
    if (load) begin
      remain_d = cnt_in;
      ptr_d    = ptr_in;
    end else if (step) begin
      remain_d = remain_q - CNT_ONE;
      ptr_d    = ptr_q + PTR_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
      ptr_q    <= '0;
    end else if (load || step) begin
      remain_q <= remain_d;
      ptr_q    <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr_q <= '0;
    else if (load) addr_q <= addr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wdata_q <= '0;
    else if (cap_en) wdata_q <= dat_in;
  end

  assign last_beat = (remain_q == CNT_ONE);

endmodule

// File: rtl/cmdseq_seq.sv
module cmdseq_seq
  import cmdseq_pkg::*;
#(
  parameter int CMD_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  op_e               cmd_op,
  input  logic              cmd_cnt_zero,
  input  logic              last_beat,
  input  logic              waitreq,
  output logic [CMD_AW-1:0] pc_q,
  output logic              cmd_rd,
  output logic              load,
  output logic              step,
  output logic              dat_rd,
  output logic              cap_en,
  output logic              bus_read,
  output logic              bus_write,
  output logic              done
);

  localparam logic [CMD_AW-1:0] PC_LAST = {CMD_AW{1'b1}};
  localparam logic [CMD_AW-1:0] PC_ONE  = CMD_AW'(1);

  st_e  state_q, state_d;
  logic pc_inc;
  logic last_cmd;

  assign last_cmd = (pc_q == PC_LAST);

  always_comb begin
    state_d = state_q;
    pc_inc  = 1'b0;
    step    = 1'b0;
    unique case (state_q)
      S_IDLE:   if (start) state_d = S_FETCH;
      S_FETCH:  state_d = S_DECODE;
      S_DECODE: begin
        if (cmd_op == OP_NOP || cmd_cnt_zero) state_d = S_NEXT;
        else if (cmd_op == OP_READ)           state_d = S_READ;
        else if (cmd_op == OP_WRITE)          state_d = S_DLOAD;
        else                                  state_d = S_DELAY;
      end
      S_DLOAD:  state_d = S_DCAP;
      S_DCAP:   state_d = S_WRITE;
      S_WRITE: begin
        if (!waitreq) begin
          step    = 1'b1;
          state_d = last_beat ? S_NEXT : S_DLOAD;
        end
      end
      S_READ: begin
        if (!waitreq) begin
          step    = 1'b1;
          state_d = last_beat ? S_NEXT : S_READ;
        end
      end
      S_DELAY: begin
        step    = 1'b1;
        state_d = last_beat ? S_NEXT : S_DELAY;
      end
      S_NEXT: begin
        if (last_cmd) state_d = S_DONE;
        else begin
          pc_inc  = 1'b1;
          state_d = S_FETCH;
        end
      end
      S_DONE:   state_d = S_DONE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc_q <= '0;
    else if (pc_inc) pc_q <= pc_q + PC_ONE;
  end

  assign cmd_rd    = (state_q == S_FETCH);
  assign load      = (state_q == S_DECODE);
  assign dat_rd    = (state_q == S_DLOAD);
  assign cap_en    = (state_q == S_DCAP);
  assign bus_write = (state_q == S_WRITE);
  assign bus_read  = (state_q == S_READ);
  assign done      = (state_q == S_DONE);

endmodule

// File: rtl/cmdseq_result_fwd.sv
module cmdseq_result_fwd #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rvalid,
  input  logic [DATA_W-1:0] rdata,
  output logic              push_q,
  output logic [DATA_W-1:0] data_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) push_q <= 1'b0;
    else        push_q <= rvalid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      data_q <= '0;
    else if (rvalid) data_q <= rdata;
  end

endmodule

// File: rtl/cmdseq_master.sv
module cmdseq_master
  import cmdseq_pkg::*;
#(
  parameter int CMD_AW = 6,
  parameter int DAT_AW = 7,
  parameter int BUS_AW = 3,
  parameter int CNT_W  = 9,
  parameter int DATA_W = 32,
  localparam int PTR_LSB = 0,
  localparam int CNT_LSB = PTR_LSB + DAT_AW,
  localparam int ADR_LSB = CNT_LSB + CNT_W,
  localparam int OP_LSB  = ADR_LSB + BUS_AW,
  localparam int CMD_W   = OP_LSB + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [CMD_AW-1:0] cmd_addr,
  output logic              cmd_rd,
  input  logic [CMD_W-1:0]  cmd_data,
  output logic [DAT_AW-1:0] dat_addr,
  output logic              dat_rd,
  input  logic [DATA_W-1:0] dat_data,
  output logic [BUS_AW-1:0] bus_address,
  output logic              bus_read,
  output logic              bus_write,
  output logic [DATA_W-1:0] bus_writedata,
  input  logic              bus_waitrequest,
  input  logic [DATA_W-1:0] bus_readdata,
  input  logic              bus_readdatavalid,
  output logic              res_push,
  output logic [DATA_W-1:0] res_data,
  output logic              done
);

  logic              rst_n_int;
  op_e               cmd_op;
  logic [BUS_AW-1:0] cmd_adr;
  logic [CNT_W-1:0]  cmd_cnt;
  logic [DAT_AW-1:0] cmd_ptr;
  logic              cmd_cnt_zero;
  logic              load, step, cap_en, last_beat;

  assign cmd_op       = op_e'(cmd_data[OP_LSB +: 2]);
  assign cmd_adr      = cmd_data[ADR_LSB +: BUS_AW];
  assign cmd_cnt      = cmd_data[CNT_LSB +: CNT_W];
  assign cmd_ptr      = cmd_data[PTR_LSB +: DAT_AW];
  assign cmd_cnt_zero = (cmd_cnt == '0);

  cmdseq_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  cmdseq_seq #(.CMD_AW(CMD_AW)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .start        (start),
    .cmd_op       (cmd_op),
    .cmd_cnt_zero (cmd_cnt_zero),
    .last_beat    (last_beat),
    .waitreq      (bus_waitrequest),
    .pc_q         (cmd_addr),
    .cmd_rd       (cmd_rd),
    .load         (load),
    .step         (step),
    .dat_rd       (dat_rd),
    .cap_en       (cap_en),
    .bus_read     (bus_read),
    .bus_write    (bus_write),
    .done         (done)
  );

  cmdseq_beat #(
    .BUS_AW (BUS_AW),
    .CNT_W  (CNT_W),
    .DAT_AW (DAT_AW),
    .DATA_W (DATA_W)
  ) u_beat (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .load      (load),
    .addr_in   (cmd_adr),
    .cnt_in    (cmd_cnt),
    .ptr_in    (cmd_ptr),
    .step      (step),
    .cap_en    (cap_en),
    .dat_in    (dat_data),
    .addr_q    (bus_address),
    .ptr_q     (dat_addr),
    .wdata_q   (bus_writedata),
    .last_beat (last_beat)
  );

  cmdseq_result_fwd #(.DATA_W(DATA_W)) u_res (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .rvalid (bus_readdatavalid),
    .rdata  (bus_readdata),
    .push_q (res_push),
    .data_q (res_data)
  );

endmodule

// File: rtl/cmdseq_master_chk.sv
module cmdseq_master_chk #(
  parameter int BUS_AW = 3,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_rd,
  input logic              dat_rd,
  input logic [BUS_AW-1:0] bus_address,
  input logic              bus_read,
  input logic              bus_write,
  input logic [DATA_W-1:0] bus_writedata,
  input logic              bus_waitrequest,
  input logic [DATA_W-1:0] bus_readdata,
  input logic              bus_readdatavalid,
  input logic              res_push,
  input logic [DATA_W-1:0] res_data,
  input logic              done
);

  a_r8_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_read && bus_waitrequest |=> bus_read && $stable(bus_address));

  a_r8_hold_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_write && bus_waitrequest |=> bus_write && $stable(bus_address) && $stable(bus_writedata));

  a_r9_push_follows: assert property (@(posedge clk) disable iff (!rst_n)
    bus_readdatavalid |=> res_push && (res_data == $past(bus_readdata)));

  a_r9_no_stray_push: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_readdatavalid |=> !res_push);

  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  a_r10_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_read && !bus_write && !cmd_rd && !dat_rd);

  a_r4_single_request: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_read && bus_write));

endmodule

bind cmdseq_master cmdseq_master_chk #(.BUS_AW(BUS_AW), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_cmdseq_master.sv
module sim_cmdseq_master;

  logic        clk = 1'b0;
  logic        rst_n, start;
  logic [5:0]  cmd_addr;
  logic        cmd_rd;
  logic [20:0] cmd_data;
  logic [6:0]  dat_addr;
  logic        dat_rd;
  logic [31:0] dat_data;
  logic [2:0]  bus_address;
  logic        bus_read, bus_write;
  logic [31:0] bus_writedata;
  logic        bus_waitrequest;
  logic [31:0] bus_readdata;
  logic        bus_readdatavalid;
  logic        res_push;
  logic [31:0] res_data;
  logic        done;

  always #4 clk = ~clk;

  cmdseq_master u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cmd_addr(cmd_addr), .cmd_rd(cmd_rd), .cmd_data(cmd_data),
    .dat_addr(dat_addr), .dat_rd(dat_rd), .dat_data(dat_data),
    .bus_address(bus_address), .bus_read(bus_read), .bus_write(bus_write),
    .bus_writedata(bus_writedata), .bus_waitrequest(bus_waitrequest),
    .bus_readdata(bus_readdata), .bus_readdatavalid(bus_readdatavalid),
    .res_push(res_push), .res_data(res_data), .done(done)
  );

  logic [20:0] cmd_mem [0:63];
  logic [31:0] dat_mem [0:127];

  int checks = 0, fails = 0;
  int mode = 0;
  bit clr = 1'b1;

  logic [2:0]  exp_ra [0:511];
  logic [2:0]  exp_wa [0:511];
  logic [31:0] exp_wd [0:511];
  int exp_nr, exp_nw, exp_cyc;

  logic [2:0]  got_ra [0:511];
  logic [2:0]  got_wa [0:511];
  logic [31:0] got_wd [0:511];
  logic [31:0] ret_log  [0:511];
  logic [31:0] push_log [0:511];
  logic [31:0] pend [0:511];
  int n_rd, n_wr, n_ret, n_push, n_stall, pend_h, pend_t;
  logic [15:0] lfsr;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic gen(input int s);
    int op, c, a, p;
    exp_nr = 0; exp_nw = 0; exp_cyc = 0;
    for (int j = 0; j < 128; j++)
      dat_mem[j] = {8'(j) ^ 8'h5A, 8'(s), 16'(j * 977 + s)};
    for (int i = 0; i < 64; i++) begin
      op = (i + s + i / 5) % 4;
      c  = (i * 3 + s * 5) % 5;
      a  = (i * 5 + s) % 8;
      p  = (i * 29 + s * 61) % 128;
      if (i == 10) begin op = 2; c = 4; p = 126; end
      if (i == 20) begin op = 3; c = 511; end
      cmd_mem[i] = {2'(op), 3'(a), 9'(c), 7'(p)};
      exp_cyc += 3;
      if (op == 1) begin
        for (int k = 0; k < c; k++) begin exp_ra[exp_nr] = 3'(a); exp_nr++; end
        exp_cyc += c;
      end else if (op == 2) begin
        for (int k = 0; k < c; k++) begin
          exp_wa[exp_nw] = 3'(a);
          exp_wd[exp_nw] = dat_mem[(p + k) % 128];
          exp_nw++;
        end
        exp_cyc += 3 * c;
      end else if (op == 3) begin
        exp_cyc += c;
      end
    end
  endtask

  // synchronous memories, one cycle read latency
  initial begin
    cmd_data = '0; dat_data = '0;
    forever begin
      @(posedge clk);
      if (cmd_rd) cmd_data <= cmd_mem[cmd_addr];
      if (dat_rd) dat_data <= dat_mem[dat_addr];
    end
  end

  // slave model: drives at falling edge, observes 1 ns before rising edge
  initial begin
    bus_waitrequest = 1'b0; bus_readdatavalid = 1'b0; bus_readdata = '0;
    forever begin
      @(negedge clk);
      if (clr) begin
        n_rd = 0; n_wr = 0; n_ret = 0; n_push = 0; n_stall = 0;
        pend_h = 0; pend_t = 0;
        lfsr = 16'hACE1 + 16'(mode);
        bus_waitrequest = 1'b0; bus_readdatavalid = 1'b0;
      end else begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (mode)
          1:       bus_waitrequest = lfsr[0] & lfsr[1];
          2:       bus_waitrequest = lfsr[2];
          3:       bus_waitrequest = lfsr[0] | lfsr[1];
          default: bus_waitrequest = 1'b0;
        endcase
        if (pend_h != pend_t && (mode == 0 || lfsr[5])) begin
          bus_readdatavalid = 1'b1;
          bus_readdata      = pend[pend_h % 512];
          ret_log[n_ret % 512] = pend[pend_h % 512];
          n_ret++; pend_h++;
        end else begin
          bus_readdatavalid = 1'b0;
        end
        #3;
        if (bus_write) begin
          if (!bus_waitrequest) begin
            got_wa[n_wr % 512] = bus_address;
            got_wd[n_wr % 512] = bus_writedata;
            n_wr++;
          end else n_stall++;
        end
        if (bus_read) begin
          if (!bus_waitrequest) begin
            got_ra[n_rd % 512] = bus_address;
            pend[pend_t % 512] = {8'hC3, 5'd0, bus_address, 16'(n_rd)};
            n_rd++; pend_t++;
          end else n_stall++;
        end
        if (res_push) begin
          push_log[n_push % 512] = res_data;
          n_push++;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int cyc, sv_wr, sv_rd;
    rst_n = 1'b0; start = 1'b0;
    for (int run = 0; run < 4; run++) begin
      rst_n = 1'b0; clr = 1'b1; mode = run;
      gen(run);
      repeat (3) @(negedge clk);
      #3;
      chk(!bus_read && !bus_write, "R1 bus idle in reset", {bus_read, bus_write}, 0);
      chk(!res_push && !done && !cmd_rd, "R1 push/done/fetch low in reset",
          {res_push, done, cmd_rd}, 0);
      @(negedge clk);
      rst_n = 1'b1; clr = 1'b0;
      repeat (6) @(negedge clk);
      chk(n_rd == 0 && n_wr == 0 && !done, "R2 quiet before start", n_rd + n_wr, 0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      while (!done && cyc < 20000) begin
        cyc++;
        start = (run == 2 && cyc == 37);
        @(negedge clk);
      end
      start = 1'b0;
      chk(done, "R10 done reached", done, 1);
      repeat (30) @(negedge clk);
      chk(cyc == exp_cyc + n_stall, "R11/R6/R7 run length", cyc, exp_cyc + n_stall);
      chk(n_rd == exp_nr, "R4/R7 read count", n_rd, exp_nr);
      for (int i = 0; i < exp_nr && i < n_rd; i++)
        chk(got_ra[i] == exp_ra[i], "R4 read address", got_ra[i], exp_ra[i]);
      chk(n_wr == exp_nw, "R5/R7 write count", n_wr, exp_nw);
      for (int i = 0; i < exp_nw && i < n_wr; i++) begin
        chk(got_wa[i] == exp_wa[i], "R3 write address", got_wa[i], exp_wa[i]);
        chk(got_wd[i] == exp_wd[i], mode == 0 ? "R5 write data" : "R8 write data under stall",
            got_wd[i], exp_wd[i]);
      end
      chk(n_push == n_ret && n_ret == n_rd, "R9 push count", n_push, n_ret);
      for (int i = 0; i < n_push && i < n_ret; i++)
        chk(push_log[i] == ret_log[i], "R9 pushed word", push_log[i], ret_log[i]);
      sv_wr = n_wr; sv_rd = n_rd;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (20) @(negedge clk);
      chk(done && n_wr == sv_wr && n_rd == sv_rd, "R10 start ignored after done",
          n_wr + n_rd, sv_wr + sv_rd);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule